// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a first-in first-out buffer of 1024 words of 18 bits that links a producer and a consumer running on two unrelated, free-running clocks. The producer presents a word with two write qualifiers. The buffer tells it, through an input-ready flag, whether there is room. The consumer sees the oldest word already waiting in an output data register. An output-ready flag says whether that register holds a valid word. The consumer takes a word by raising two read qualifiers and an output enable on a read-clock edge.

The first word written into an empty buffer moves into the output register by itself, a fixed number of read-clock edges after it was written. No read request is needed for this. Later words move into the register one per qualified read edge. Each side keeps its own pointer and sees the other side's pointer in Gray code through a two-stage synchronizer. This fixes how many edges each flag takes to respond to the far side. The pad driver is modelled by a separate drive indication that follows the output enable. A single active-low reset, sampled on both clocks, clears the pointers and both flags.

Top module: `fifo_fall`

## Requirements
- R1: While `rst_n` is low and each clock is running, `in_ready` and `out_ready` are low from the first edge of their own clock onward.
- R2: After `rst_n` is released with the buffer empty, `in_ready` is still low after the first rising `wclk` edge and is high after the second.
- R3: A write takes place on a rising `wclk` edge exactly when `we_a`, `we_b` and `in_ready` are all high. Every accepted 18-bit word leaves through `dout` unchanged and in write order.
- R4: The first word written into an empty buffer is in `dout` with `out_ready` high after the third rising `rclk` edge following the write edge. After the first and second of those edges `out_ready` is still low. `re_a`, `re_b` and `oe` have no effect on this transfer.
- R5: While `out_ready` is high, the word in `dout` is consumed on a rising `rclk` edge only when `re_a`, `re_b` and `oe` are all high. With any of the three low, `dout` and `out_ready` hold.
- R6: The read edge that consumes the last stored word also drives `out_ready` low. A read attempted while `out_ready` is low changes nothing.
- R7: The storage array plus the output register hold 1025 words. With no reads, `in_ready` falls after the 1025th accepted write and stays low. Further write attempts are dropped.
- R8: When the buffer is full, `in_ready` is still low after the first rising `wclk` edge that follows the first read and is high after the second.
- R9: `dout_drive` equals `oe` at all times. When it is low, the data outputs are to be taken as not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| we_a | input | 1 | First write qualifier, active high |
| we_b | input | 1 | Second write qualifier, active high |
| din | input | 18 | Write data |
| in_ready | output | 1 | High while there is room for a word |
| re_a | input | 1 | First read qualifier, active high |
| re_b | input | 1 | Second read qualifier, active high |
| oe | input | 1 | Output enable; also qualifies reads |
| dout | output | 18 | Output data register |
| out_ready | output | 1 | High while `dout` holds a valid word |
| dout_drive | output | 1 | Indication that `dout` is being driven |

## Verification
Flag and data results fall due on a fixed count of edges. Input-ready returns two write edges after the event that freed room. The first word and output-ready appear three read edges after the first write. A consumed word is replaced, or output-ready drops, on the same read edge. The directed cases count exactly those edges with waits on the clock concerned and sample a moment after the last edge. The two clocks' edges never coincide, so "after" is always unambiguous. In the random phases, every word is compared against a reference queue at the falling read edge before the edge that consumes it, under three read-to-write clock ratios.

// File: rtl/fifo_fall_pkg.sv
package fifo_fall_pkg;

  // Gray code to binary for values up to 32 bits (zero-extended input)
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/ff_sync2.sv
module ff_sync2 #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ff_mem.sv
module ff_mem #(
  parameter int W  = 18,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wdata;
  end

  // registered read port doubles as the output data register
  always_ff @(posedge rclk) begin
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ff_wr_side.sv
module ff_wr_side #(
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic          we_b,
  input  logic [AW:0]   rq_gray,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wptr_gray,
  output logic          in_ready
);
  logic [AW:0] wbin, wbin_nx;
  logic        live1, live2, full;

  assign full     = (wptr_gray == {~rq_gray[AW:AW-1], rq_gray[AW-2:0]});
  assign in_ready = live2 & ~full;
  assign wr_en    = we_a & we_b & in_ready;
  assign wbin_nx  = wbin + 1'b1;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin      <= '0;
      wptr_gray <= '0;
      live1     <= 1'b0;
      live2     <= 1'b0;
    end else begin
      live1 <= 1'b1;
      live2 <= live1;
      if (wr_en) begin
        wbin      <= wbin_nx;
        wptr_gray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/ff_rd_side.sv
module ff_rd_side #(
  parameter int AW = 10
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re_a,
  input  logic          re_b,
  input  logic          oe,
  input  logic [AW:0]   wq_gray,
  output logic          load,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic          out_ready
);
  logic [AW:0] rbin, rbin_nx;
  logic        avail, take;

  assign avail   = (wq_gray != rptr_gray);
  assign take    = out_ready & re_a & re_b & oe;
  assign load    = avail & (~out_ready | take);
  assign rbin_nx = rbin + 1'b1;
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin      <= '0;
      rptr_gray <= '0;
      out_ready <= 1'b0;
    end else if (load) begin
      rbin      <= rbin_nx;
      rptr_gray <= rbin_nx ^ (rbin_nx >> 1);
      out_ready <= 1'b1;
    end else if (take) begin
      out_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_fall.sv
module fifo_fall #(
  parameter int WIDTH      = 18,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             we_a,
  input  logic             we_b,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             re_a,
  input  logic             re_b,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready,
  output logic             dout_drive
);
  localparam int PW = DEPTH_LOG2 + 1;

  logic [PW-1:0]         wptr_g, rptr_g, rq_g, wq_g;
  logic [DEPTH_LOG2-1:0] waddr, raddr;
  logic                  wr_en, load;

  ff_wr_side #(.AW(DEPTH_LOG2)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .we_a(we_a), .we_b(we_b), .rq_gray(rq_g),
    .wr_en(wr_en), .waddr(waddr), .wptr_gray(wptr_g), .in_ready(in_ready)
  );

  ff_rd_side #(.AW(DEPTH_LOG2)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .re_a(re_a), .re_b(re_b), .oe(oe),
    .wq_gray(wq_g), .load(load), .raddr(raddr), .rptr_gray(rptr_g),
    .out_ready(out_ready)
  );

  ff_sync2 #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rptr_g), .q(rq_g)
  );

  ff_sync2 #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wptr_g), .q(wq_g)
  );

  ff_mem #(.W(WIDTH), .AW(DEPTH_LOG2)) u_mem (
    .wclk(wclk), .wen(wr_en), .waddr(waddr), .wdata(din),
    .rclk(rclk), .ren(load), .raddr(raddr), .rdata(dout)
  );

  assign dout_drive = oe;
endmodule

// File: rtl/fifo_fall_chk.sv
module fifo_fall_chk
  import fifo_fall_pkg::*;
#(
  parameter int AW = 10
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_ready,
  input logic        re_a,
  input logic        re_b,
  input logic        oe,
  input logic [AW:0] wptr_g,
  input logic [AW:0] rq_g,
  input logic [AW:0] rptr_g,
  input logic [AW:0] wq_g
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] wb32, rb32;
  logic [AW:0] occ;

  assign wb32 = gray_to_bin(32'(wptr_g));
  assign rb32 = gray_to_bin(32'(rq_g));
  assign occ  = wb32[AW:0] - rb32[AW:0];

  AST_IR_LOW_IN_RESET: assert property (@(posedge wclk) !rst_n |=> !in_ready); // R1
  AST_OR_LOW_IN_RESET: assert property (@(posedge rclk) !rst_n |=> !out_ready); // R1
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n) occ <= (AW+1)'(DEPTH)); // R7
  AST_FULL_WRITE_DROPPED: assert property (@(posedge wclk) disable iff (!rst_n) !in_ready |=> $stable(wptr_g)); // R7
  AST_EMPTY_READ_DROPPED: assert property (@(posedge rclk) disable iff (!rst_n) (!out_ready && wq_g == rptr_g) |=> ($stable(rptr_g) && !out_ready)); // R6
  AST_OR_FALL_NEEDS_READ: assert property (@(posedge rclk) disable iff (!rst_n) ($fell(out_ready) && $past(rst_n)) |-> $past(re_a && re_b && oe)); // R5
endmodule

bind fifo_fall fifo_fall_chk #(.AW(DEPTH_LOG2)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .in_ready(in_ready),
  .out_ready(out_ready), .re_a(re_a), .re_b(re_b), .oe(oe),
  .wptr_g(wptr_g), .rq_g(rq_g), .rptr_g(rptr_g), .wq_g(wq_g)
);

// File: tb/fifo_fall_test.sv
module fifo_fall_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W   = 18;
  localparam int CAP = 1025;

  logic         wclk, rclk, rst_n, we_a, we_b, re_a, re_b, oe;
  logic [W-1:0] din, dout;
  logic         in_ready, out_ready, dout_drive;

  int           rhalf = 17;
  int           n_run = 0, n_fail = 0;
  logic [W-1:0] refq [$];
  bit           wdone;

  fifo_fall uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .we_a(we_a), .we_b(we_b),
    .din(din), .in_ready(in_ready), .re_a(re_a), .re_b(re_b), .oe(oe),
    .dout(dout), .out_ready(out_ready), .dout_drive(dout_drive)
  );

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #0.3; forever #(rhalf) rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // compare the word about to be consumed with the reference queue
  task automatic consume(input string req);
    if (refq.size() == 0) begin
      chk(0, req, "out_ready with empty model", 1, 0);
    end else begin
      chk(dout == refq[0], req, "dout order", int'(dout), int'(refq[0]));
      void'(refq.pop_front());
    end
  endtask

  task automatic drain(input string req);
    while (refq.size() > 0) begin
      @(negedge rclk);
      re_a = 1; re_b = 1; oe = 1;
      if (out_ready) consume(req);
    end
    @(negedge rclk);
    re_a = 0; re_b = 0; oe = 0;
  endtask

  task automatic random_phase(input int half, input int attempts);
    rhalf = half;
    wdone = 0;
    fork
      begin
        for (int i = 0; i < attempts; i++) begin
          @(negedge wclk);
          we_a = ($urandom % 4) != 0;
          we_b = ($urandom % 4) != 0;
          din  = W'($urandom);
          if (we_a && we_b && in_ready) refq.push_back(din); // R3
        end
        @(negedge wclk);
        we_a = 0; we_b = 0;
        wdone = 1;
      end
      begin
        while (!wdone || refq.size() > 0) begin
          @(negedge rclk);
          re_a = ($urandom % 6) != 0;
          re_b = ($urandom % 6) != 0;
          oe   = ($urandom % 6) != 0;
          #0.1;
          chk(dout_drive == oe, "R9", "dout_drive", int'(dout_drive), int'(oe));
          if (re_a && re_b && oe && out_ready) consume("R3");
        end
        @(negedge rclk);
        re_a = 0; re_b = 0; oe = 0;
      end
    join
  endtask

  initial begin
    int cnt;
    logic [W-1:0] first;
    void'($urandom(32'h1f0a5));
    rst_n = 0; we_a = 0; we_b = 0; re_a = 0; re_b = 0; oe = 0; din = '0;
    repeat (20) @(posedge wclk);
    #1;
    chk(in_ready == 0, "R1", "in_ready in reset", int'(in_ready), 0);
    chk(out_ready == 0, "R1", "out_ready in reset", int'(out_ready), 0);
    chk(dout_drive == 0, "R9", "dout_drive with oe low", int'(dout_drive), 0);

    // R2: release and count write edges
    @(negedge wclk); rst_n = 1;
    @(posedge wclk); #1;
    chk(in_ready == 0, "R2", "in_ready after 1st edge", int'(in_ready), 0);
    @(posedge wclk); #1;
    chk(in_ready == 1, "R2", "in_ready after 2nd edge", int'(in_ready), 1);

    // R4: first word falls through on the third read edge, enables low
    @(negedge wclk); we_a = 1; we_b = 1; first = 18'h2a5c3; din = first;
    @(posedge wclk);
    fork begin @(negedge wclk); we_a = 0; we_b = 0; end join_none
    @(posedge rclk); #1;
    chk(out_ready == 0, "R4", "out_ready after 1st rclk", int'(out_ready), 0);
    @(posedge rclk); #1;
    chk(out_ready == 0, "R4", "out_ready after 2nd rclk", int'(out_ready), 0);
    @(posedge rclk); #1;
    chk(out_ready == 1, "R4", "out_ready after 3rd rclk", int'(out_ready), 1);
    chk(dout == first, "R4", "fall-through word", int'(dout), int'(first));

    // R5: any qualifier low holds the word
    @(negedge rclk); re_a = 1; re_b = 1; oe = 0;
    repeat (3) @(posedge rclk); #1;
    chk(out_ready == 1 && dout == first, "R5", "hold with oe low", int'(dout), int'(first));
    chk(dout_drive == 0, "R9", "dout_drive follows oe", int'(dout_drive), 0);
    @(negedge rclk); re_a = 1; re_b = 0; oe = 1;
    repeat (3) @(posedge rclk); #1;
    chk(out_ready == 1 && dout == first, "R5", "hold with re_b low", int'(dout), int'(first));
    chk(dout_drive == 1, "R9", "dout_drive follows oe", int'(dout_drive), 1);

    // R6: consuming the only word drops out_ready on that edge
    @(negedge rclk); re_b = 1;
    @(posedge rclk); #1;
    chk(out_ready == 0, "R6", "out_ready after last read", int'(out_ready), 0);
    @(negedge rclk); re_a = 0; re_b = 0; oe = 0;
    @(negedge rclk); re_a = 1; re_b = 1; oe = 1;
    repeat (3) @(posedge rclk); #1;
    chk(out_ready == 0, "R6", "read while empty", int'(out_ready), 0);
    @(negedge rclk); re_a = 0; re_b = 0; oe = 0;

    // R7: fill with reads off
    rhalf = 3;
    cnt = 0;
    forever begin
      @(negedge wclk);
      if (!in_ready) break;
      we_a = 1; we_b = 1; din = W'($urandom);
      refq.push_back(din);
      cnt++;
    end
    chk(cnt == CAP, "R7", "accepted writes until full", cnt, CAP);
    repeat (20) begin @(negedge wclk); din = W'($urandom); end
    chk(in_ready == 0, "R7", "in_ready stays low", int'(in_ready), 0);
    @(negedge wclk); we_a = 0; we_b = 0;

    // R8: one read, then count write edges
    @(negedge rclk); re_a = 1; re_b = 1; oe = 1;
    consume("R8");
    @(posedge rclk);
    fork begin @(negedge rclk); re_a = 0; re_b = 0; oe = 0; end join_none
    @(posedge wclk); #1;
    chk(in_ready == 0, "R8", "in_ready after 1st wclk", int'(in_ready), 0);
    @(posedge wclk); #1;
    chk(in_ready == 1, "R8", "in_ready after 2nd wclk", int'(in_ready), 1);

    // R3/R7: remaining words come out in order, extra writes were dropped
    drain("R7");
    repeat (4) @(posedge rclk); #1;
    chk(out_ready == 0, "R6", "out_ready after drain", int'(out_ready), 0);

    random_phase(3, 2500);
    random_phase(5, 2500);
    random_phase(17, 1500);
    repeat (4) @(posedge rclk); #1;
    chk(out_ready == 0, "R6", "out_ready after random run", int'(out_ready), 0);
    chk(in_ready == 1, "R3", "in_ready after random run", int'(in_ready), 1);
    report();
  end

  initial begin
    #1500us;
    chk(0, "WDOG", "watchdog expired", 0, 1);
    report();
  end
endmodule